// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a virtual address into a physical one for a single requester. The virtual address is cut into an upper index field and a lower offset field. The index, together with a bank-select register, picks one entry of an internal translation table. The entry supplies a frame number, which takes the place of the index bits. The offset is passed through unchanged beneath it. Each entry also holds an offset limit, read, write and execute permissions, a present flag and a modified flag. Before a translation is granted, the access is checked against the limit, the permissions and the present flag.

The table holds four banks of 256 entries. It is loaded one entry at a time through a configuration write port. An address-space switch is a single write to the bank-select register: requests accepted after that write look up the newly selected bank. Requests use a valid/ready handshake. Each accepted request gets a registered response exactly one cycle later. A configuration write takes priority over a request in the same cycle.

Top module: `paged_xlate_unit`

## Requirements
- R1: After reset, rsp_valid is 0, req_ready is 1, the bank select is 0, and every table entry reads as not present, so any request page-faults.
- R2: A request accepted (req_valid and req_ready high) at clock edge N produces rsp_valid high after edge N with rsp_paddr = {entry frame, vaddr[15:0]}, where the entry index is vaddr[23:16]. rsp_valid is low after any edge at which no request was accepted.
- R3: An offset vaddr[15:0] greater than the entry's limit field gives rsp_prot_fault = 1. An offset equal to the limit is allowed.
- R4: The req_kind encoding is 0 = read, 1 = write, 2 = execute and 3 = reserved. An access whose kind lacks the matching permission bit (cfg_perm bit 0 = read, bit 1 = write, bit 2 = execute), or that uses kind 3, gives rsp_prot_fault = 1.
- R5: A request to an entry whose present flag is 0 gives rsp_page_fault = 1 and rsp_prot_fault = 0, whatever the limit and permissions say. The two fault outputs are never both high.
- R6: A write that completes without a fault sets the entry's modified flag. rsp_dirty reports the flag as it stands after the access. Reads, execute accesses and faulting writes leave the flag unchanged.
- R7: The bank select (written with base_we, value base_sel) chooses which of the four banks a request indexes. The new value applies to requests accepted after the edge at which it is written.
- R8: A configuration write (cfg_we) stores frame, limit, permissions and present flag at {cfg_bank, cfg_idx}, and clears that entry's modified flag. req_ready is low during any cycle in which cfg_we is high.
- R9: When either fault output is high, rsp_paddr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_bank | input | 2 | Bank of the entry to write |
| cfg_idx | input | 8 | Index of the entry to write |
| cfg_frame | input | 16 | Frame number for the entry |
| cfg_limit | input | 16 | Largest allowed offset for the entry |
| cfg_perm | input | 3 | Permissions: bit0 read, bit1 write, bit2 execute |
| cfg_present | input | 1 | Present flag for the entry |
| base_we | input | 1 | Bank-select register write strobe |
| base_sel | input | 2 | New bank-select value |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_vaddr | input | 24 | Virtual address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Response valid (one cycle after acceptance) |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_page_fault | output | 1 | Entry not present |
| rsp_prot_fault | output | 1 | Limit or permission violation |
| rsp_dirty | output | 1 | Entry's modified flag after this access |

## Verification
Every response field is due in the cycle that follows the accepting edge. The bench drives a request at a falling edge and lets the rising edge accept it. It reads rsp_valid, rsp_paddr, both fault outputs and rsp_dirty at the next falling edge, when the request has already been withdrawn. Table and bank-select writes take effect at the edge where they are strobed. For that reason a check that depends on them always comes at least one full cycle after the strobe is removed. req_ready is sampled combinationally, a short delay after cfg_we rises, inside the same cycle.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

    parameter int VA_W    = 24;
    parameter int IDX_W   = 8;
    parameter int FRAME_W = 16;
    parameter int BANKS   = 4;

    localparam int OFF_W  = VA_W - IDX_W;
    localparam int BANK_W = $clog2(BANKS);
    localparam int PA_W   = FRAME_W + OFF_W;
    localparam int ADDR_W = BANK_W + IDX_W;
    localparam int DEPTH  = BANKS << IDX_W;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [OFF_W-1:0]   limit;
        logic               can_x;
        logic               can_w;
        logic               can_r;
    } entry_t;

    typedef struct packed {
        logic            valid;
        logic [PA_W-1:0] paddr;
        logic            page_fault;
        logic            prot_fault;
        logic            dirty;
    } resp_t;

    function automatic logic perm_allows(entry_t e, acc_e k);
        case (k)
            ACC_READ:  return e.can_r;
            ACC_WRITE: return e.can_w;
            ACC_EXEC:  return e.can_x;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pxu_table.sv
module pxu_table
    import pxu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  entry_t            wr_entry,
    input  logic              wr_present,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              mark_dirty,
    output entry_t            lk_entry,
    output logic              lk_present,
    output logic              lk_dirty
);

    entry_t           store [DEPTH];
    logic [DEPTH-1:0] present_q;
    logic [DEPTH-1:0] dirty_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            present_q <= '0;
            dirty_q   <= '0;
        end else if (wr_en) begin
            present_q[wr_addr] <= wr_present;
            dirty_q[wr_addr]   <= 1'b0;
        end else if (mark_dirty) begin
            dirty_q[lk_addr] <= 1'b1;
        end
    end

    always_comb begin
        lk_entry   = store[lk_addr];
        lk_present = present_q[lk_addr];
        lk_dirty   = dirty_q[lk_addr];
    end

endmodule

// File: rtl/pxu_check.sv
module pxu_check
    import pxu_pkg::*;
(
    input  entry_t           entry,
    input  logic             present,
    input  logic [OFF_W-1:0] offset,
    input  acc_e             kind,
    output logic             page_fault,
    output logic             prot_fault,
    output logic             write_ok
);

    logic over_limit;
    logic denied;

    always_comb begin
        over_limit = offset > entry.limit;
        denied     = !perm_allows(entry, kind);
        page_fault = !present;
        prot_fault = present && (over_limit || denied);
        write_ok   = present && !over_limit && !denied && (kind == ACC_WRITE);
    end

endmodule

// File: rtl/pxu_resp.sv
module pxu_resp
    import pxu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  resp_t nxt,
    output resp_t cur
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/paged_xlate_unit.sv
module paged_xlate_unit
    import pxu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [BANK_W-1:0]   cfg_bank,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [FRAME_W-1:0]  cfg_frame,
    input  logic [OFF_W-1:0]    cfg_limit,
    input  logic [2:0]          cfg_perm,
    input  logic                cfg_present,
    input  logic                base_we,
    input  logic [BANK_W-1:0]   base_sel,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [VA_W-1:0]     req_vaddr,
    input  logic [1:0]          req_kind,
    output logic                rsp_valid,
    output logic [PA_W-1:0]     rsp_paddr,
    output logic                rsp_page_fault,
    output logic                rsp_prot_fault,
    output logic                rsp_dirty
);

    logic [BANK_W-1:0] bank_q;
    logic              accept;
    logic [IDX_W-1:0]  vidx;
    logic [OFF_W-1:0]  voff;
    logic [ADDR_W-1:0] lk_addr;
    entry_t            wr_entry;
    entry_t            lk_entry;
    logic              lk_present;
    logic              lk_dirty;
    logic              pf;
    logic              prf;
    logic              wok;
    resp_t             nxt;
    resp_t             cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
        end else if (base_we) begin
            bank_q <= base_sel;
        end
    end

    assign req_ready = !cfg_we;
    assign accept    = req_valid && req_ready;
    assign vidx      = req_vaddr[VA_W-1:OFF_W];
    assign voff      = req_vaddr[OFF_W-1:0];
    assign lk_addr   = {bank_q, vidx};

    always_comb begin
        wr_entry.frame = cfg_frame;
        wr_entry.limit = cfg_limit;
        wr_entry.can_r = cfg_perm[0];
        wr_entry.can_w = cfg_perm[1];
        wr_entry.can_x = cfg_perm[2];
    end

    pxu_table u_table (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (cfg_we),
        .wr_addr    ({cfg_bank, cfg_idx}),
        .wr_entry   (wr_entry),
        .wr_present (cfg_present),
        .lk_addr    (lk_addr),
        .mark_dirty (accept && wok),
        .lk_entry   (lk_entry),
        .lk_present (lk_present),
        .lk_dirty   (lk_dirty)
    );

    pxu_check u_check (
        .entry      (lk_entry),
        .present    (lk_present),
        .offset     (voff),
        .kind       (acc_e'(req_kind)),
        .page_fault (pf),
        .prot_fault (prf),
        .write_ok   (wok)
    );

    always_comb begin
        nxt.valid      = accept;
        nxt.page_fault = accept && pf;
        nxt.prot_fault = accept && prf;
        nxt.paddr      = (accept && !pf && !prf) ? {lk_entry.frame, voff} : '0;
        nxt.dirty      = accept && lk_present && (lk_dirty || wok);
    end

    pxu_resp u_resp (
        .clk (clk),
        .rst (rst),
        .nxt (nxt),
        .cur (cur)
    );

    assign rsp_valid      = cur.valid;
    assign rsp_paddr      = cur.paddr;
    assign rsp_page_fault = cur.page_fault;
    assign rsp_prot_fault = cur.prot_fault;
    assign rsp_dirty      = cur.dirty;

endmodule

// File: rtl/pxu_sva.sv
module pxu_sva
    import pxu_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               cfg_we,
    input logic               req_valid,
    input logic               req_ready,
    input logic [VA_W-1:0]    req_vaddr,
    input logic               rsp_valid,
    input logic [PA_W-1:0]    rsp_paddr,
    input logic               rsp_page_fault,
    input logic               rsp_prot_fault
);

    AST_RSP_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid); // R2

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> !rsp_valid); // R2

    AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (rsp_page_fault || rsp_prot_fault
            || rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]))); // R2

    AST_FAULTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !(rsp_page_fault && rsp_prot_fault)); // R5

    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (rst)
        (rsp_page_fault || rsp_prot_fault) |-> rsp_paddr == '0); // R9

    AST_CFG_BLOCKS_REQ: assert property (@(posedge clk) disable iff (rst)
        cfg_we |-> !req_ready); // R8

    AST_FAULT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        (rsp_page_fault || rsp_prot_fault) |-> rsp_valid); // R5

endmodule

bind paged_xlate_unit pxu_sva u_sva (
    .clk            (clk),
    .rst            (rst),
    .cfg_we         (cfg_we),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_vaddr      (req_vaddr),
    .rsp_valid      (rsp_valid),
    .rsp_paddr      (rsp_paddr),
    .rsp_page_fault (rsp_page_fault),
    .rsp_prot_fault (rsp_prot_fault)
);

// File: tb/paged_xlate_unit_tb_top.sv
`timescale 1ns/1ps
module paged_xlate_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_bank = '0;
    logic [7:0]  cfg_idx = '0;
    logic [15:0] cfg_frame = '0;
    logic [15:0] cfg_limit = '0;
    logic [2:0]  cfg_perm = '0;
    logic        cfg_present = 1'b0;
    logic        base_we = 1'b0;
    logic [1:0]  base_sel = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_page_fault;
    logic        rsp_prot_fault;
    logic        rsp_dirty;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    paged_xlate_unit dut_i (
        .clk            (clk),
        .rst            (rst),
        .cfg_we         (cfg_we),
        .cfg_bank       (cfg_bank),
        .cfg_idx        (cfg_idx),
        .cfg_frame      (cfg_frame),
        .cfg_limit      (cfg_limit),
        .cfg_perm       (cfg_perm),
        .cfg_present    (cfg_present),
        .base_we        (base_we),
        .base_sel       (base_sel),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_vaddr      (req_vaddr),
        .req_kind       (req_kind),
        .rsp_valid      (rsp_valid),
        .rsp_paddr      (rsp_paddr),
        .rsp_page_fault (rsp_page_fault),
        .rsp_prot_fault (rsp_prot_fault),
        .rsp_dirty      (rsp_dirty)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic load_entry(logic [1:0] bank, logic [7:0] idx, logic [15:0] frame,
                              logic [15:0] limit, logic [2:0] perm, logic present);
        @(negedge clk);
        cfg_we = 1'b1; cfg_bank = bank; cfg_idx = idx; cfg_frame = frame;
        cfg_limit = limit; cfg_perm = perm; cfg_present = present;
        #1;
        check("R8 req_ready low during cfg write", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_bank(logic [1:0] b);
        @(negedge clk);
        base_we = 1'b1; base_sel = b;
        @(negedge clk);
        base_we = 1'b0;
    endtask

    task automatic access(string tag, logic [23:0] va, logic [1:0] kind,
                          logic [31:0] exp_pa, logic exp_pf, logic exp_prf, logic exp_dirty);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_kind = kind;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
        check({tag, " paddr"}, rsp_paddr, exp_pa);
        check({tag, " page_fault"}, {31'd0, rsp_page_fault}, {31'd0, exp_pf});
        check({tag, " prot_fault"}, {31'd0, rsp_prot_fault}, {31'd0, exp_prf});
        check({tag, " dirty"}, {31'd0, rsp_dirty}, {31'd0, exp_dirty});
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        check("R1 req_ready after reset", {31'd0, req_ready}, 32'd1);
        access("R1 unloaded entry", 24'h12_3456, 2'd0, 32'd0, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check("R2 no response without request", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic test_translate();
        load_entry(2'd0, 8'h12, 16'hABCD, 16'hFFFF, 3'b111, 1'b1);
        load_entry(2'd0, 8'hFF, 16'h0001, 16'hFFFF, 3'b111, 1'b1);
        access("R2 basic read", 24'h12_3456, 2'd0, 32'hABCD_3456, 1'b0, 1'b0, 1'b0);
        access("R2 top index exec", 24'hFF_0000, 2'd2, 32'h0001_0000, 1'b0, 1'b0, 1'b0);
        access("R2 max offset", 24'hFF_FFFF, 2'd0, 32'h0001_FFFF, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic test_limit();
        load_entry(2'd0, 8'h20, 16'h5000, 16'h0100, 3'b011, 1'b1);
        access("R3 offset at limit", 24'h20_0100, 2'd0, 32'h5000_0100, 1'b0, 1'b0, 1'b0);
        access("R3 R9 offset past limit", 24'h20_0101, 2'd0, 32'd0, 1'b0, 1'b1, 1'b0);
        access("R3 write past limit no dirty", 24'h20_FFFF, 2'd1, 32'd0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic test_perm();
        load_entry(2'd0, 8'h30, 16'h6000, 16'hFFFF, 3'b001, 1'b1);
        access("R4 read allowed", 24'h30_0010, 2'd0, 32'h6000_0010, 1'b0, 1'b0, 1'b0);
        access("R4 write denied", 24'h30_0010, 2'd1, 32'd0, 1'b0, 1'b1, 1'b0);
        access("R4 exec denied", 24'h30_0010, 2'd2, 32'd0, 1'b0, 1'b1, 1'b0);
        access("R4 reserved kind", 24'h12_0000, 2'd3, 32'd0, 1'b0, 1'b1, 1'b0);
        access("R6 denied write left clean", 24'h30_0010, 2'd0, 32'h6000_0010, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic test_page_fault();
        load_entry(2'd0, 8'h40, 16'h7000, 16'h0010, 3'b111, 1'b0);
        access("R5 not present", 24'h40_0000, 2'd0, 32'd0, 1'b1, 1'b0, 1'b0);
        access("R5 not present beats limit", 24'h40_8000, 2'd1, 32'd0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic test_dirty();
        access("R6 read keeps clean", 24'h12_0001, 2'd0, 32'hABCD_0001, 1'b0, 1'b0, 1'b0);
        access("R6 write sets dirty", 24'h12_0002, 2'd1, 32'hABCD_0002, 1'b0, 1'b0, 1'b1);
        access("R6 dirty persists", 24'h12_0003, 2'd2, 32'hABCD_0003, 1'b0, 1'b0, 1'b1);
        access("R6 other entry clean", 24'hFF_0003, 2'd0, 32'h0001_0003, 1'b0, 1'b0, 1'b0);
        load_entry(2'd0, 8'h12, 16'hABCE, 16'hFFFF, 3'b111, 1'b1);
        access("R8 reload clears dirty", 24'h12_0004, 2'd0, 32'hABCE_0004, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic test_bank();
        load_entry(2'd1, 8'h12, 16'h7777, 16'hFFFF, 3'b111, 1'b1);
        access("R7 bank0 before switch", 24'h12_0042, 2'd0, 32'hABCE_0042, 1'b0, 1'b0, 1'b0);
        set_bank(2'd1);
        access("R7 bank1 after switch", 24'h12_0042, 2'd1, 32'h7777_0042, 1'b0, 1'b0, 1'b1);
        access("R7 bank1 unloaded idx", 24'h20_0000, 2'd0, 32'd0, 1'b1, 1'b0, 1'b0);
        set_bank(2'd0);
        access("R7 bank0 untouched", 24'h12_0042, 2'd0, 32'hABCE_0042, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_translate();
        test_limit();
        test_perm();
        test_page_fault();
        test_dirty();
        test_bank();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule